// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a single-bit data stream by a programmable whole number of clock cycles. The data passes through a fixed minimum section and then through a chain of stages of 1, 2, 4, … 2^(CODE_W-1) cycles. A 2:1 multiplexer either switches each stage into the path or bypasses it. One control bit selects each stage, so the added delay equals the unsigned value of the control code. One more single-cycle stage is used only by the force-to-maximum override.

A control register sits in front of the stage selects. While `hold_en` is low it is transparent, and while `hold_en` is high it keeps its contents. Two overrides act on it: `force_min` clears it and `force_max` fills it. The top control bit does not select a stage. It drives a complementary cascade pair, so that several instances can be chained to give a longer range. An active-low enable replaces the incoming data with zeros. A control change affects only the samples that enter after the change. Bits already inside a stage stay where they are, so the output is only meaningful once the chain has been refilled.

Top module: `pdl_delay_line`

## Requirements
- R1: With no override active, a one-cycle pulse on `din` appears on `dout` as a one-cycle pulse exactly MIN_DLY + code posedges later, where code = `ctrl_in[CODE_W-1:0]` read as unsigned with bit 0 as the LSB.
- R2: Control bit k adds 2^k cycles, and the contributions of all set bits add up.
- R3: A code of zero still gives a delay of MIN_DLY cycles (MIN_DLY is at least 1).
- R4: While `hold_en` is low, a new `ctrl_in` takes effect in the same cycle, both on the stage selects and on the cascade pair.
- R5: While `hold_en` is high, the register keeps the value that was loaded at the last posedge where `hold_en` was low, and `ctrl_in` has no effect.
- R6: `force_min` high clears the whole register (delay MIN_DLY, `casc_p` low). The cleared value stays after release as long as `hold_en` is high.
- R7: `force_max` high with `force_min` low fills the register. This gives MIN_DLY + 2^CODE_W cycles (one step past the all-ones code) with `casc_p` high, and the value stays after release as long as `hold_en` is high.
- R8: If both overrides are high, `force_min` wins.
- R9: While `en_n` is high, zeros enter the chain in place of `din`.
- R10: `casc_p` equals the effective control bit CODE_W, and `casc_n` is always its complement.
- R11: Reset clears every stage and the register, so after reset `dout` is low until new data has crossed the chain.

Top module parameters: CODE_W (default 10), MIN_DLY (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data in |
| en_n | input | 1 | Active-low data enable |
| hold_en | input | 1 | High: register holds; low: transparent |
| force_min | input | 1 | Clear register (minimum delay) |
| force_max | input | 1 | Fill register (maximum delay + 1 step) |
| ctrl_in | input | CODE_W+1 | Delay code [CODE_W-1:0] and cascade bit [CODE_W] |
| dout | output | 1 | Delayed data out |
| casc_p | output | 1 | Cascade bit, true |
| casc_n | output | 1 | Cascade bit, complement |

## Verification
The two overrides can be raised in the same cycle, and both can also meet a hold or a transparent load. The bench drives `force_min` and `force_max` together with an all-ones code. It then judges the result by the cascade pair and by a measured pulse delay of MIN_DLY. The bench also pulses each override for one cycle while the register is held. This checks that the forced value survives the release, and the delay it then measures must be the forced one, not the code on `ctrl_in`.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
    localparam int unsigned DEF_CODE_W  = 10;
    localparam int unsigned DEF_MIN_DLY = 2;
endpackage

// File: rtl/pdl_ctrl_latch.sv
// Control register with hold, overrides and effective-code output.
// Layout of the register: [CODE_W+1] overflow step, [CODE_W] cascade bit,
// [CODE_W-1:0] stage selects.
module pdl_ctrl_latch #(
    parameter int unsigned CODE_W = pdl_pkg::DEF_CODE_W,
    localparam int unsigned HW    = CODE_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_en,
    input  logic            force_min,
    input  logic            force_max,
    input  logic [CODE_W:0] ctrl_in,
    output logic [HW-1:0]   eff_code,
    output logic [HW-1:0]   held_code
);
    typedef struct packed {
        logic [HW-1:0] held;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_min)
            st_d.held = '0;
        else if (force_max)
            st_d.held = '1;
        else if (!hold_en)
            st_d.held = {1'b0, ctrl_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The register's next value is what the data path uses right now.
    // This makes the transparent mode and the overrides take effect at once.
    assign eff_code  = st_d.held;
    assign held_code = st_q.held;
endmodule

// File: rtl/pdl_stage.sv
// One switchable delay stage: LEN flops plus a bypass multiplexer.
// The flops shift every cycle, so a bypassed stage is flushed as well.
module pdl_stage #(
    parameter int unsigned LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic sel,
    output logic dout
);
    logic [LEN-1:0] sr_d, sr_q;

    generate
        if (LEN == 1) begin : g_one
            always_comb sr_d = din;
        end else begin : g_many
            always_comb sr_d = {sr_q[LEN-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sel ? sr_q[LEN-1] : din;
endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line #(
    parameter int unsigned CODE_W  = pdl_pkg::DEF_CODE_W,
    parameter int unsigned MIN_DLY = pdl_pkg::DEF_MIN_DLY
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic            en_n,
    input  logic            hold_en,
    input  logic            force_min,
    input  logic            force_max,
    input  logic [CODE_W:0] ctrl_in,
    output logic            dout,
    output logic            casc_p,
    output logic            casc_n
);
    localparam int unsigned HW = CODE_W + 2;

    logic [HW-1:0] eff_code;
    logic [HW-1:0] held_code;
    logic          gated_in;
    logic [CODE_W+1:0] tap;

    pdl_ctrl_latch #(.CODE_W(CODE_W)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_en   (hold_en),
        .force_min (force_min),
        .force_max (force_max),
        .ctrl_in   (ctrl_in),
        .eff_code  (eff_code),
        .held_code (held_code)
    );

    assign gated_in = din & ~en_n;

    // Fixed minimum section, always in the path.
    pdl_stage #(.LEN(MIN_DLY)) i_fixed (
        .clk (clk), .rst_n (rst_n), .din (gated_in), .sel (1'b1), .dout (tap[0])
    );

    // Stages weighted by powers of two, LSB first.
    generate
        for (genvar k = 0; k < CODE_W; k++) begin : g_stage
            pdl_stage #(.LEN(1 << k)) i_stage (
                .clk (clk), .rst_n (rst_n), .din (tap[k]),
                .sel (eff_code[k]), .dout (tap[k+1])
            );
        end
    endgenerate

    // Single extra step used only by the maximum override.
    pdl_stage #(.LEN(1)) i_over (
        .clk (clk), .rst_n (rst_n), .din (tap[CODE_W]),
        .sel (eff_code[HW-1]), .dout (tap[CODE_W+1])
    );

    assign dout   = tap[CODE_W+1];
    assign casc_p = eff_code[CODE_W];
    assign casc_n = ~eff_code[CODE_W];
endmodule

// File: rtl/pdl_delay_line_chk.sv
module pdl_delay_line_chk #(
    parameter int unsigned CODE_W = pdl_pkg::DEF_CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_en,
    input logic              force_min,
    input logic              force_max,
    input logic [CODE_W:0]   ctrl_in,
    input logic              casc_p,
    input logic [CODE_W+1:0] held_code
);
    p_min_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_min |=> held_code == '0);

    p_max_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_max && !force_min) |=> held_code == '1);

    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && !force_min && !force_max) |=> $stable(held_code));

    p_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_en && !force_min && !force_max) |-> casc_p == ctrl_in[CODE_W]);

    p_min_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && force_max) |-> !casc_p);
endmodule

bind pdl_delay_line pdl_delay_line_chk #(.CODE_W(CODE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_en   (hold_en),
    .force_min (force_min),
    .force_max (force_max),
    .ctrl_in   (ctrl_in),
    .casc_p    (casc_p),
    .held_code (held_code)
);

// File: tb/test_pdl_delay_line.sv
module test_pdl_delay_line;
    localparam int CODE_W  = 10;
    localparam int MIN_DLY = 2;
    localparam int LIMIT   = MIN_DLY + (1 << CODE_W) + 8;

    typedef struct packed {
        logic        le;
        logic        fmin;
        logic        fmax;
        logic        en_n;
        logic [10:0] ctrl;
        logic        exp_ok;
        logic [10:0] exp_steps;
        logic        exp_casc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,11'h000,1'b1,11'd0,   1'b0,4'd3},  // R3 zero code
        '{1'b0,1'b0,1'b0,1'b0,11'h001,1'b1,11'd1,   1'b0,4'd2},  // R2 bit 0
        '{1'b0,1'b0,1'b0,1'b0,11'h002,1'b1,11'd2,   1'b0,4'd2},  // R2 bit 1
        '{1'b0,1'b0,1'b0,1'b0,11'h004,1'b1,11'd4,   1'b0,4'd2},  // R2 bit 2
        '{1'b0,1'b0,1'b0,1'b0,11'h425,1'b1,11'd37,  1'b1,4'd10}, // R10 cascade bit set
        '{1'b0,1'b0,1'b0,1'b0,11'h200,1'b1,11'd512, 1'b0,4'd2},  // R2 top bit
        '{1'b0,1'b0,1'b0,1'b0,11'h7FF,1'b1,11'd1023,1'b1,4'd1},  // R1 all ones
        '{1'b0,1'b0,1'b0,1'b0,11'h2A5,1'b1,11'd677, 1'b0,4'd1},  // R1 mixed
        '{1'b0,1'b1,1'b0,1'b0,11'h7FF,1'b1,11'd0,   1'b0,4'd6},  // R6 force min
        '{1'b0,1'b0,1'b1,1'b0,11'h005,1'b1,11'd1024,1'b1,4'd7},  // R7 force max
        '{1'b0,1'b1,1'b1,1'b0,11'h7FF,1'b1,11'd0,   1'b0,4'd8},  // R8 both
        '{1'b0,1'b0,1'b0,1'b1,11'h003,1'b0,11'd0,   1'b0,4'd9}   // R9 gated
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0, en_n = 1'b0, hold_en = 1'b0, force_min = 1'b0, force_max = 1'b0;
    logic [CODE_W:0] ctrl_in = '0;
    logic dout, casc_p, casc_n;

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pdl_delay_line #(.CODE_W(CODE_W), .MIN_DLY(MIN_DLY)) i_pdl_delay_line (
        .clk (clk), .rst_n (rst_n), .din (din), .en_n (en_n), .hold_en (hold_en),
        .force_min (force_min), .force_max (force_max), .ctrl_in (ctrl_in),
        .dout (dout), .casc_p (casc_p), .casc_n (casc_n)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic flush();
        din = 1'b0;
        repeat (LIMIT) @(negedge clk);
    endtask

    // Sends a one-cycle pulse and returns the first cycle at which dout is
    // high (0 if none) and whether the pulse lasted exactly one cycle.
    task automatic measure(output int n, output int one_wide);
        n = 0;
        one_wide = 0;
        din = 1'b1;
        for (int i = 1; i <= LIMIT; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 1) din = 1'b0;
            if (n != 0 && i == n + 1) begin
                one_wide = dout ? 0 : 1;
                break;
            end
            if (dout && n == 0) n = i;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n, w, highs;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 dout", int'(dout), 0);
        check("R10 casc_p", int'(casc_p), 0);
        check("R10 casc_n", int'(casc_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[v]) begin
            hold_en   = VECS[v].le;
            force_min = VECS[v].fmin;
            force_max = VECS[v].fmax;
            en_n      = VECS[v].en_n;
            ctrl_in   = VECS[v].ctrl;
            flush();
            measure(n, w);
            check($sformatf("R%0d row%0d delay", VECS[v].req, v), n,
                  VECS[v].exp_ok ? MIN_DLY + int'(VECS[v].exp_steps) : 0);
            if (VECS[v].exp_ok)
                check($sformatf("R%0d row%0d width", VECS[v].req, v), w, 1);
            check($sformatf("R%0d row%0d casc_p", VECS[v].req, v), int'(casc_p), int'(VECS[v].exp_casc));
            check($sformatf("R%0d row%0d casc_n", VECS[v].req, v), int'(casc_n), int'(!VECS[v].exp_casc));
        end
        force_min = 1'b0; force_max = 1'b0; en_n = 1'b0;

        // R5: load 7 with cascade bit, hold, then change ctrl_in
        hold_en = 1'b0;
        ctrl_in = 11'h407;
        @(negedge clk);
        hold_en = 1'b1;
        ctrl_in = 11'h000;
        flush();
        measure(n, w);
        check("R5 held delay", n, MIN_DLY + 7);
        check("R5 held casc_p", int'(casc_p), 1);

        // R6: pulse force_min while held, release, value stays cleared
        ctrl_in = 11'h7FF;
        force_min = 1'b1;
        @(negedge clk);
        force_min = 1'b0;
        flush();
        measure(n, w);
        check("R6 after release delay", n, MIN_DLY);
        check("R6 after release casc_p", int'(casc_p), 0);

        // R7: pulse force_max while held, release, value stays full
        ctrl_in = 11'h000;
        force_max = 1'b1;
        @(negedge clk);
        force_max = 1'b0;
        flush();
        measure(n, w);
        check("R7 after release delay", n, MIN_DLY + 1024);
        check("R7 after release casc_p", int'(casc_p), 1);

        // R11: fill the chain with ones, reset, and check nothing leaks out
        din = 1'b1;
        repeat (40) @(negedge clk);
        din = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        highs = 0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (dout) highs++;
        end
        check("R11 no residue", highs, 0);
        check("R11 casc_p cleared", int'(casc_p), 0);
        measure(n, w);
        check("R11 cleared register delay", n, MIN_DLY);

        // R4: transparent change takes effect on the cascade pair at once
        hold_en = 1'b0;
        ctrl_in = 11'h400;
        #1;
        check("R4 casc_p immediate", int'(casc_p), 1);
        check("R4 casc_n immediate", int'(casc_n), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule